// File: doc/BRIEF.md
# Sampled-Waveform Constant-Fraction Timing Discriminator

This block timestamps negative-going pulses in a stream of 12-bit, baseline-subtracted waveform samples. For every accepted sample it forms a bipolar signal: an older copy of the waveform, taken a set number of samples back, minus the current sample scaled by a set fraction. A pulse is timed where this bipolar signal moves from zero or above to below zero. At that point the block reports a sample index and a 6-bit sub-sample fraction found by straight-line interpolation between the two bracketing sums.

Noise near the baseline is kept out by an arming rule. The detector only accepts a crossing after some sample has gone below a programmable negative level. It drops back to idle after each reported crossing. The stream is qualified by a valid bit. Cycles without valid change nothing.

Top module: `cfd_timer`

## Requirements
- R1: After reset, `hit` is 0, `hit_index` is 0 and `hit_frac` is 0.
- R2: For the k-th accepted sample x[k] (signed two's complement), the bipolar sum is s[k] = x[k-D] - floor(G*x[k]/256). G is the unsigned `cfg_gain`. Samples from before reset count as 0.
- R3: The delay D is taken from `cfg_delay` and may be 1 to 15. A value of 0 acts as 1.
- R4: A sample with x[k] < -L, where L is the unsigned `cfg_arm_level`, arms the detector from the next accepted sample on. No crossing is reported while the detector is idle.
- R5: When armed, a sample with s[k-1] >= 0 and s[k] < 0 is a crossing. `hit` is high for exactly one cycle, in the cycle after the clock edge that accepted sample k.
- R6: Every crossing returns the detector to idle. The crossing sample itself does not arm it, even when it lies below -L.
- R7: Accepted samples are numbered from 0 after reset, modulo 2^16. On a crossing, `hit_index` is k-1, the index of the last sample whose sum was non-negative.
- R8: On a crossing, `hit_frac` is floor(64*s[k-1]/(s[k-1]-s[k])). This is the position of the zero in units of 1/64 sample after sample k-1.
- R9: Cycles with `smp_valid` low change no state, whatever `smp_data` holds. `hit_index` and `hit_frac` keep their values between crossings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Qualifies `smp_data` in this cycle |
| smp_data | input | 12 | Signed waveform sample, baseline removed |
| cfg_delay | input | 4 | Delay of the older copy in samples |
| cfg_gain | input | 8 | Fraction applied to the current sample, in 1/256 |
| cfg_arm_level | input | 11 | Arming level magnitude (arms below its negative) |
| hit | output | 1 | One-cycle crossing strobe |
| hit_index | output | 16 | Index of the last non-negative sample before the zero |
| hit_frac | output | 6 | Sub-sample position of the zero, in 1/64 |

## Verification
Two things can land on the same sample: a crossing, and a value deep enough to arm the detector. Both happen when the crossing sample itself lies below the arming level. The bench builds exactly that sample and follows it with a shallow second crossing. That second crossing would be reported only if the crossing sample had re-armed the detector. The case passes when it yields a single hit, with the hand-computed index and fraction. A companion case shows the same disarm behaviour with an ordinary crossing sample.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  typedef enum logic {
    ARM_IDLE  = 1'b0,
    ARM_READY = 1'b1
  } arm_state_e;
endpackage

// File: rtl/cfd_tap_delay.sv
module cfd_tap_delay #(
  parameter int W     = 12,
  parameter int DEPTH = 15,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic [W-1:0]     din,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     dout
);
  logic [W-1:0] taps [DEPTH];

  // One register stage per sample of delay; stage i holds x[k-1-i].
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [W-1:0] q;
    logic [W-1:0] d;
    if (i == 0) begin : g_head
      assign d = din;
    end else begin : g_body
      assign d = g_stage[i-1].q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (shift_en) q <= d;
    end
    assign taps[i] = q;
  end

  logic [SEL_W-1:0] tap_sel;
  always_comb begin
    if (sel == '0)                 tap_sel = '0;
    else if (sel > SEL_W'(DEPTH))  tap_sel = SEL_W'(DEPTH - 1);
    else                           tap_sel = sel - SEL_W'(1);
    dout = taps[tap_sel];
  end
endmodule

// File: rtl/cfd_mix.sv
module cfd_mix #(
  parameter int SMP_W  = 12,
  parameter int GAIN_W = 8,
  parameter int SUM_W  = 14
) (
  input  logic [SMP_W-1:0]        cur,
  input  logic [SMP_W-1:0]        dly,
  input  logic [GAIN_W-1:0]       gain,
  output logic signed [SUM_W-1:0] sum
);
  localparam int PROD_W = SMP_W + GAIN_W + 1;

  logic signed [PROD_W-1:0] prod;
  logic signed [SMP_W:0]    scaled;

  always_comb begin
    prod   = PROD_W'($signed(cur)) * PROD_W'($signed({1'b0, gain}));
    // Arithmetic drop of the fraction bits: floor(G*x/2^GAIN_W).
    scaled = $signed(prod[PROD_W-1:GAIN_W]);
    sum    = SUM_W'($signed(dly)) - SUM_W'(scaled);
  end
endmodule

// File: rtl/cfd_zc_detect.sv
module cfd_zc_detect
  import cfd_pkg::*;
#(
  parameter int SMP_W  = 12,
  parameter int SUM_W  = 14,
  parameter int TIME_W = 6,
  parameter int IDX_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    valid,
  input  logic [SMP_W-1:0]        sample,
  input  logic [SMP_W-2:0]        level,
  input  logic signed [SUM_W-1:0] sum,
  output logic                    hit,
  output logic [IDX_W-1:0]        hit_index,
  output logic [TIME_W-1:0]       hit_frac
);
  localparam int NUM_W    = SUM_W - 1 + TIME_W;
  localparam int FRAC_MAX = (1 << TIME_W) - 1;

  logic signed [SUM_W-1:0] prev_q, prev_d;
  arm_state_e              arm_q, arm_d;
  logic [IDX_W-1:0]        cnt_q, cnt_d;
  logic                    hit_q, hit_d;
  logic [IDX_W-1:0]        idx_q, idx_d;
  logic [TIME_W-1:0]       frac_q, frac_d;

  logic signed [SMP_W:0]   lvl_test;
  logic                    below;
  logic                    crossing;
  logic signed [SUM_W:0]   den_s;
  logic [SUM_W-1:0]        den_g;
  logic [NUM_W-1:0]        num_u;
  logic [NUM_W-1:0]        quo;
  logic [TIME_W-1:0]       frac_calc;

  always_comb begin
    lvl_test = (SMP_W+1)'($signed(sample)) + $signed({2'b00, level});
    below    = lvl_test[SMP_W];
    crossing = valid && (arm_q == ARM_READY) && !prev_q[SUM_W-1] && sum[SUM_W-1];

    // Linear interpolation of the zero between s[k-1] and s[k].
    den_s = $signed({prev_q[SUM_W-1], prev_q}) - $signed({sum[SUM_W-1], sum});
    if (den_s <= 0) den_g = SUM_W'(1);
    else            den_g = den_s[SUM_W-1:0];
    num_u = {prev_q[SUM_W-2:0], {TIME_W{1'b0}}};
    quo   = num_u / NUM_W'(den_g);
    if (quo > NUM_W'(FRAC_MAX)) frac_calc = TIME_W'(FRAC_MAX);
    else                        frac_calc = quo[TIME_W-1:0];
  end

  always_comb begin
    cnt_d  = cnt_q;
    prev_d = prev_q;
    arm_d  = arm_q;
    idx_d  = idx_q;
    frac_d = frac_q;
    hit_d  = crossing;
    if (valid) begin
      cnt_d  = cnt_q + IDX_W'(1);
      prev_d = sum;
      if (crossing)   arm_d = ARM_IDLE;
      else if (below) arm_d = ARM_READY;
    end
    if (crossing) begin
      idx_d  = cnt_q - IDX_W'(1);
      frac_d = frac_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= '0;
      arm_q  <= ARM_IDLE;
      hit_q  <= 1'b0;
      idx_q  <= '0;
      frac_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      prev_q <= prev_d;
      arm_q  <= arm_d;
      hit_q  <= hit_d;
      idx_q  <= idx_d;
      frac_q <= frac_d;
    end
  end

  assign hit       = hit_q;
  assign hit_index = idx_q;
  assign hit_frac  = frac_q;
endmodule

// File: rtl/cfd_timer.sv
module cfd_timer #(
  parameter int SMP_W   = 12,
  parameter int MAX_DLY = 15,
  parameter int GAIN_W  = 8,
  parameter int TIME_W  = 6,
  parameter int IDX_W   = 16,
  localparam int DLY_W  = $clog2(MAX_DLY + 1),
  localparam int SUM_W  = SMP_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic [GAIN_W-1:0] cfg_gain,
  input  logic [SMP_W-2:0]  cfg_arm_level,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_index,
  output logic [TIME_W-1:0] hit_frac
);
  logic [SMP_W-1:0]        dly_smp;
  logic signed [SUM_W-1:0] bip_sum;

  cfd_tap_delay #(
    .W(SMP_W), .DEPTH(MAX_DLY), .SEL_W(DLY_W)
  ) u_dly (
    .clk(clk), .rst_n(rst_n), .shift_en(smp_valid),
    .din(smp_data), .sel(cfg_delay), .dout(dly_smp)
  );

  cfd_mix #(
    .SMP_W(SMP_W), .GAIN_W(GAIN_W), .SUM_W(SUM_W)
  ) u_mix (
    .cur(smp_data), .dly(dly_smp), .gain(cfg_gain), .sum(bip_sum)
  );

  cfd_zc_detect #(
    .SMP_W(SMP_W), .SUM_W(SUM_W), .TIME_W(TIME_W), .IDX_W(IDX_W)
  ) u_det (
    .clk(clk), .rst_n(rst_n), .valid(smp_valid), .sample(smp_data),
    .level(cfg_arm_level), .sum(bip_sum),
    .hit(hit), .hit_index(hit_index), .hit_frac(hit_frac)
  );
endmodule

// File: rtl/cfd_timer_chk.sv
module cfd_timer_chk #(
  parameter int TIME_W = 6,
  parameter int IDX_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              hit,
  input logic [IDX_W-1:0]  hit_index,
  input logic [TIME_W-1:0] hit_frac
);
  logic [IDX_W-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen_q <= '0;
    else if (smp_valid) seen_q <= seen_q + IDX_W'(1);
  end

  // R5
  hit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);

  // R9
  hit_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(smp_valid));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> ($stable(hit_index) && $stable(hit_frac)));

  // R7
  index_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (hit_index == IDX_W'(seen_q - IDX_W'(2))));
endmodule

bind cfd_timer cfd_timer_chk #(.TIME_W(TIME_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
  .hit(hit), .hit_index(hit_index), .hit_frac(hit_frac)
);

// File: tb/cfd_timer_tb.sv
module cfd_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_data = '0;
  logic [3:0]  cfg_delay = 4'd1;
  logic [7:0]  cfg_gain = '0;
  logic [10:0] cfg_arm_level = '0;
  logic        hit;
  logic [15:0] hit_index;
  logic [5:0]  hit_frac;

  int tests = 0;
  int fails = 0;

  int wave [0:127];
  int exp_idx [0:63];
  int exp_frac [0:63];
  int exp_n;
  int got_idx [0:63];
  int got_frac [0:63];
  int got_n = 0;

  always #2 clk = ~clk;

  cfd_timer u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .cfg_delay(cfg_delay), .cfg_gain(cfg_gain), .cfg_arm_level(cfg_arm_level),
    .hit(hit), .hit_index(hit_index), .hit_frac(hit_frac)
  );

  always @(negedge clk) begin
    if (rst_n && hit) begin
      if (got_n < 64) begin
        got_idx[got_n]  = int'(hit_index);
        got_frac[got_n] = int'(hit_frac);
      end
      got_n++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic do_reset(input int d, input int g, input int lvl);
    @(negedge clk);
    rst_n         = 1'b0;
    smp_valid     = 1'b0;
    cfg_delay     = 4'(d);
    cfg_gain      = 8'(g);
    cfg_arm_level = 11'(lvl);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    got_n = 0;
  endtask

  task automatic clear_wave();
    for (int i = 0; i < 128; i++) wave[i] = 0;
  endtask

  task automatic make_pulse(input int amp);
    clear_wave();
    for (int i = 8; i <= 10; i++) wave[i] = -(amp * (i - 7)) / 3;
    for (int i = 11; i <= 18; i++) wave[i] = -(amp * (19 - i)) / 9;
  endtask

  // Expected hits from the requirement formulas (R2..R8).
  task automatic model(input int n, input int d, input int g, input int lvl);
    int de;
    int prev;
    bit armed;
    de    = (d == 0) ? 1 : d;
    prev  = 0;
    armed = 1'b0;
    exp_n = 0;
    for (int k = 0; k < n; k++) begin
      int xd;
      int s;
      xd = (k >= de) ? wave[k-de] : 0;
      s  = xd - ((g * wave[k]) >>> 8);
      if (armed && prev >= 0 && s < 0) begin
        exp_idx[exp_n]  = k - 1;
        exp_frac[exp_n] = (prev * 64) / (prev - s);
        exp_n++;
        armed = 1'b0;
      end else if (wave[k] < -lvl) begin
        armed = 1'b1;
      end
      prev = s;
    end
  endtask

  // want: -1 no count rule, -2 at least one hit, else exact count
  task automatic run_case(input string req, input int n, input int d,
                          input int g, input int lvl, input int gap,
                          input int want);
    do_reset(d, g, lvl);
    model(n, d, g, lvl);
    for (int k = 0; k < n; k++) begin
      smp_valid = 1'b1;
      smp_data  = wave[k][11:0];
      @(negedge clk);
      for (int j = 0; j < gap; j++) begin
        smp_valid = 1'b0;
        smp_data  = 12'h830;
        @(negedge clk);
      end
    end
    smp_valid = 1'b0;
    smp_data  = 12'h830;
    repeat (4) @(negedge clk);
    if (want == -2) check(exp_n > 0, req, "stimulus yields a crossing", exp_n, 1);
    else if (want >= 0) check(got_n == want, req, "hand count", got_n, want);
    check(got_n == exp_n, {req, " R5"}, "hit count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n && i < 64; i++) begin
      check(got_idx[i] == exp_idx[i], "R7", "hit index", got_idx[i], exp_idx[i]);
      check(got_frac[i] == exp_frac[i], "R8", "hit fraction", got_frac[i], exp_frac[i]);
    end
    if (exp_n > 0 && exp_n <= 64) begin
      check(int'(hit_index) == exp_idx[exp_n-1], "R9", "index held after idle",
            int'(hit_index), exp_idx[exp_n-1]);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(hit == 1'b0, "R1", "hit in reset", int'(hit), 0);
    check(hit_index == 16'd0, "R1", "index in reset", int'(hit_index), 0);
    check(hit_frac == 6'd0, "R1", "fraction in reset", int'(hit_frac), 0);
  endtask

  task automatic t_basic();
    make_pulse(800);
    run_case("R2", 40, 4, 128, 100, 0, -2);
  endtask

  task automatic t_below_level();
    make_pulse(80);
    run_case("R4", 40, 4, 128, 100, 0, 0);
  endtask

  task automatic t_disarm();
    clear_wave();
    wave[2] = -200; wave[4] = 40; wave[5] = -40; wave[6] = 40; wave[7] = -40;
    run_case("R6", 12, 1, 128, 100, 0, 1);
    if (got_n > 0) begin
      check(got_idx[0] == 2, "R7", "disarm case index", got_idx[0], 2);
      check(got_frac[0] == 21, "R8", "disarm case fraction", got_frac[0], 21);
    end
  endtask

  task automatic t_coincide();
    clear_wave();
    wave[2] = -300; wave[3] = -150; wave[5] = -60; wave[6] = 60;
    run_case("R6", 10, 1, 128, 100, 0, 1);
    if (got_n > 0) begin
      check(got_idx[0] == 2, "R7", "coincident case index", got_idx[0], 2);
      check(got_frac[0] == 25, "R8", "coincident case fraction", got_frac[0], 25);
    end
  endtask

  task automatic t_gaps();
    make_pulse(800);
    run_case("R9", 40, 4, 128, 100, 2, -2);
  endtask

  task automatic t_long_delay();
    make_pulse(1500);
    run_case("R3", 60, 15, 255, 200, 0, -2);
  endtask

  task automatic t_zero_delay();
    make_pulse(600);
    run_case("R3", 40, 0, 64, 100, 0, -2);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_basic();
    t_below_level();
    t_disarm();
    t_coincide();
    t_gaps();
    t_long_delay();
    t_zero_delay();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule